// File: doc/BRIEF.md
# External Memory Cycle Sequencer

This block runs read and write cycles on an external asynchronous memory with an 8-bit data bus and a 19-bit address. It acts as bus master only while an outside arbiter grants it the bus. The host issues one command: a start address, a byte count, a direction and a fill option. Write bytes arrive on a ready/valid stream, and read bytes leave on a valid-qualified stream.

On the memory side the block drives the address, an active-low memory request, active-low read and write strobes, and the data bus with its output enable. A burst keeps the request low from the first byte to the last. The address steps by one for each byte, and only the read or write strobe pulses once per byte.

Fill mode drives one fixed byte for the whole burst and takes nothing from the write stream. Address setup time and strobe widths are parameters given in clock cycles.

Top module: `xmem_seq`

## Requirements
- R1: After reset all three strobes are high, the data output enable is low, `rd_valid` and `done` are low, and no command is accepted.
- R2: `mem_ctl_oe` follows `bus_owned` one cycle later, and `cmd_ready` is high only when the block is idle, ownership is granted and `mem_ctl_oe` is already high. While `mem_ctl_oe` is low, the address and strobe outputs count as released.
- R3: A write drops memory request when the command is accepted. It then holds the address for at least SETUP_W cycles before the write strobe falls, and holds the write strobe low for exactly WR_W cycles while the data bus is driven. The write strobe rises one cycle before memory request rises.
- R4: A read keeps the data output enable low and holds the read strobe low for exactly RD_W cycles. It samples `mem_din` on the last low cycle and presents that byte on `rd_data` with a one-cycle `rd_valid` in the cycle the read strobe rises.
- R5: A burst of N bytes lowers memory request exactly once and keeps it low across all N bytes. It produces exactly N strobe pulses, at addresses start, start+1, …, start+N-1.
- R6: In fill mode, `cmd_fill_byte` is driven on every byte of the burst, and `wr_ready` stays low.
- R7: A streamed write takes exactly one `wr_data` byte per written address, in order. The write strobe does not fall until that byte has been accepted, so stalls on `wr_valid` do not corrupt data.
- R8: A command of length 0 raises `done` in the cycle after acceptance, with no strobe pulse and no memory-request activity.
- R9: `done` is a single-cycle pulse, raised in the same cycle that memory request returns high.
- R10: The burst address wraps modulo 2^19, so the byte after 0x7FFFF goes to 0x00000.
- R11: The read and write strobes are never low together, and either strobe is low only while memory request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_owned | input | 1 | Bus ownership granted by the arbiter |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_addr | input | ADDR_W (19) | Start address |
| cmd_len | input | LEN_W (16) | Number of bytes, 0 allowed |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_fill | input | 1 | Write the fixed fill byte instead of stream data |
| cmd_fill_byte | input | 8 | Byte used in fill mode |
| wr_valid | input | 1 | Write stream byte valid |
| wr_ready | output | 1 | Write stream byte taken |
| wr_data | input | 8 | Write stream byte |
| rd_valid | output | 1 | Read byte valid (one cycle) |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Command finished pulse |
| mem_addr | output | ADDR_W (19) | Memory address |
| mem_ctl_oe | output | 1 | Drive enable for address and strobes |
| mem_mreq_n | output | 1 | Memory request, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_dout | output | 8 | Data driven onto the bus |
| mem_dout_oe | output | 1 | Data bus drive enable |
| mem_din | input | 8 | Data read from the bus |

## Verification
The sequencer is tested with single-byte writes and reads, and with five-byte bursts. The streamed write is run once with `wr_valid` always high and once with it stalling every other cycle, which shows whether the strobe waits for data or uses a stale byte. A fill burst is read back to tell fixed-byte driving apart from stream consumption. A zero-length command and a burst that crosses 0x7FFFF exercise the two edges of the address and length handling. A memory model in the bench answers strobes from its own contents, so read data, pulse widths, setup time and per-byte addresses are all compared with values the bench works out from the requirements.

// File: rtl/xmem_pkg.sv
`timescale 1ns/1ps
package xmem_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_STROBE,
        SQ_HOLD
    } sq_state_e;

    typedef struct packed {
        sq_state_e          st;
        logic               is_wr;
        logic               is_fill;
        logic               ctl_oe;
        logic               dout_oe;
        logic               mreq_n;
        logic               rd_n;
        logic               wr_n;
        logic [BYTE_W-1:0]  dout;
        logic               rd_valid;
        logic [BYTE_W-1:0]  rd_data;
        logic               done;
    } sq_regs_t;
endpackage

// File: rtl/xmem_tmr.sv
`timescale 1ns/1ps
// Loadable down-counter; zero_o is high once the loaded count has run out.
module xmem_tmr #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/xmem_ctr.sv
`timescale 1ns/1ps
// Loadable counter that steps up or down by one; wraps at its width.
module xmem_ctr #(
    parameter int W         = 8,
    parameter bit STEP_DOWN = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         step_i,
    output logic [W-1:0] val_o
);
    logic [W-1:0] val_d, val_q, stepped;

    generate
        if (STEP_DOWN) begin : g_down
            assign stepped = val_q - 1'b1;
        end else begin : g_up
            assign stepped = val_q + 1'b1;
        end
    endgenerate

    always_comb begin
        val_d = val_q;
        if (load_i)      val_d = load_val_i;
        else if (step_i) val_d = stepped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign val_o = val_q;
endmodule

// File: rtl/xmem_seq.sv
`timescale 1ns/1ps
module xmem_seq
    import xmem_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int LEN_W   = 16,
    parameter int SETUP_W = 1,
    parameter int WR_W    = 2,
    parameter int RD_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_owned,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_write,
    input  logic              cmd_fill,
    input  logic [7:0]        cmd_fill_byte,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ctl_oe,
    output logic              mem_mreq_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [7:0]        mem_dout,
    output logic              mem_dout_oe,
    input  logic [7:0]        mem_din
);
    localparam int MAX_W = (WR_W > RD_W) ? ((WR_W > SETUP_W) ? WR_W : SETUP_W)
                                         : ((RD_W > SETUP_W) ? RD_W : SETUP_W);
    localparam int TMR_W = $clog2(MAX_W + 1);
    localparam logic [TMR_W-1:0] SETUP_LD = TMR_W'(SETUP_W - 1);
    localparam logic [TMR_W-1:0] WR_LD    = TMR_W'(WR_W - 1);
    localparam logic [TMR_W-1:0] RD_LD    = TMR_W'(RD_W - 1);

    sq_regs_t q, d;

    logic              tmr_load, tmr_zero;
    logic [TMR_W-1:0]  tmr_val;
    logic              a_load, a_step;
    logic              n_load, n_step;
    logic [LEN_W-1:0]  n_left;
    logic              accept, stream_wr, go;

    xmem_tmr #(.W(TMR_W)) tmr_i (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load),
        .load_val_i(tmr_val), .zero_o(tmr_zero)
    );

    xmem_ctr #(.W(ADDR_W), .STEP_DOWN(1'b0)) addr_ctr_i (
        .clk(clk), .rst_n(rst_n), .load_i(a_load), .load_val_i(cmd_addr),
        .step_i(a_step), .val_o(mem_addr)
    );

    xmem_ctr #(.W(LEN_W), .STEP_DOWN(1'b1)) left_ctr_i (
        .clk(clk), .rst_n(rst_n), .load_i(n_load), .load_val_i(cmd_len),
        .step_i(n_step), .val_o(n_left)
    );

    assign cmd_ready = (q.st == SQ_IDLE) && q.ctl_oe && bus_owned;
    assign accept    = cmd_valid && cmd_ready;
    assign stream_wr = q.is_wr && !q.is_fill;
    assign wr_ready  = (q.st == SQ_SETUP) && stream_wr && tmr_zero;
    assign go        = tmr_zero && (!stream_wr || wr_valid);

    always_comb begin
        d          = q;
        d.ctl_oe   = bus_owned;
        d.rd_valid = 1'b0;
        d.done     = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = SETUP_LD;
        a_load     = 1'b0;
        a_step     = 1'b0;
        n_load     = 1'b0;
        n_step     = 1'b0;
        unique case (q.st)
            SQ_IDLE: begin
                if (accept) begin
                    if (cmd_len == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.st      = SQ_SETUP;
                        d.is_wr   = cmd_write;
                        d.is_fill = cmd_write && cmd_fill;
                        d.mreq_n  = 1'b0;
                        d.dout_oe = cmd_write;
                        if (cmd_write && cmd_fill) d.dout = cmd_fill_byte;
                        a_load   = 1'b1;
                        n_load   = 1'b1;
                        tmr_load = 1'b1;
                    end
                end
            end
            SQ_SETUP: begin
                if (go) begin
                    d.st     = SQ_STROBE;
                    tmr_load = 1'b1;
                    if (q.is_wr) begin
                        d.wr_n  = 1'b0;
                        tmr_val = WR_LD;
                        if (stream_wr) d.dout = wr_data;
                    end else begin
                        d.rd_n  = 1'b0;
                        tmr_val = RD_LD;
                    end
                end
            end
            SQ_STROBE: begin
                if (tmr_zero) begin
                    d.st   = SQ_HOLD;
                    d.wr_n = 1'b1;
                    d.rd_n = 1'b1;
                    n_step = 1'b1;
                    if (!q.is_wr) begin
                        d.rd_valid = 1'b1;
                        d.rd_data  = mem_din;
                    end
                end
            end
            SQ_HOLD: begin
                if (n_left == '0) begin
                    d.st      = SQ_IDLE;
                    d.mreq_n  = 1'b1;
                    d.dout_oe = 1'b0;
                    d.done    = 1'b1;
                end else begin
                    d.st     = SQ_SETUP;
                    a_step   = 1'b1;
                    tmr_load = 1'b1;
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: SQ_IDLE, is_wr: 1'b0, is_fill: 1'b0, ctl_oe: 1'b0,
                   dout_oe: 1'b0, mreq_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                   dout: '0, rd_valid: 1'b0, rd_data: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign rd_valid    = q.rd_valid;
    assign rd_data     = q.rd_data;
    assign done        = q.done;
    assign mem_ctl_oe  = q.ctl_oe;
    assign mem_mreq_n  = q.mreq_n;
    assign mem_rd_n    = q.rd_n;
    assign mem_wr_n    = q.wr_n;
    assign mem_dout    = q.dout;
    assign mem_dout_oe = q.dout_oe;
endmodule

// File: rtl/xmem_seq_chk.sv
`timescale 1ns/1ps
module xmem_seq_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_owned,
    input logic              done,
    input logic              mem_ctl_oe,
    input logic              mem_dout_oe,
    input logic              mem_mreq_n,
    input logic              mem_rd_n,
    input logic              mem_wr_n,
    input logic [ADDR_W-1:0] mem_addr
);
    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_wr_n));
    // R11
    strobe_in_mreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n || !mem_wr_n) |-> !mem_mreq_n);
    // R3
    addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_wr_n) || $fell(mem_rd_n)) |-> $stable(mem_addr));
    // R3
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> mem_dout_oe);
    // R4
    rd_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> !mem_dout_oe);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    done_mreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> mem_mreq_n);
    // R2
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_owned |=> !mem_ctl_oe);
endmodule

bind xmem_seq xmem_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_owned(bus_owned), .done(done),
    .mem_ctl_oe(mem_ctl_oe), .mem_dout_oe(mem_dout_oe),
    .mem_mreq_n(mem_mreq_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .mem_addr(mem_addr)
);

// File: tb/xmem_seq_tb_top.sv
`timescale 1ns/1ps
module xmem_seq_tb_top;
    localparam int AW = 19;
    localparam int LW = 16;
    localparam int WRW = 2;
    localparam int RDW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_owned = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [AW-1:0] cmd_addr = '0;
    logic [LW-1:0] cmd_len = '0;
    logic cmd_write = 1'b0, cmd_fill = 1'b0;
    logic [7:0] cmd_fill_byte = '0;
    logic wr_valid = 1'b0;
    logic wr_ready;
    logic [7:0] wr_data = '0;
    logic rd_valid;
    logic [7:0] rd_data;
    logic done;
    logic [AW-1:0] mem_addr;
    logic mem_ctl_oe, mem_mreq_n, mem_rd_n, mem_wr_n, mem_dout_oe;
    logic [7:0] mem_dout;
    logic [7:0] mem_din = '0;

    always #2 clk = ~clk;

    xmem_seq dut_i (
        .clk(clk), .rst_n(rst_n), .bus_owned(bus_owned),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_write(cmd_write), .cmd_fill(cmd_fill),
        .cmd_fill_byte(cmd_fill_byte), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
        .mem_addr(mem_addr), .mem_ctl_oe(mem_ctl_oe), .mem_mreq_n(mem_mreq_n),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_dout(mem_dout),
        .mem_dout_oe(mem_dout_oe), .mem_din(mem_din)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model and bench-side reference contents
    logic [7:0] mem [int];
    logic [7:0] ref_mem [int];

    always @(posedge mem_wr_n)
        if (mem_mreq_n === 1'b0 && mem_dout_oe === 1'b1)
            mem[int'(mem_addr)] = mem_dout;

    always @(negedge clk)
        mem_din <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;

    // write stream driver
    logic [7:0] wq[$];
    bit stall_en = 1'b0;
    bit took = 1'b0;
    int phase = 0;
    always @(negedge clk) begin
        if (took) void'(wq.pop_front());
        phase++;
        wr_valid = (wq.size() > 0) && !(stall_en && phase[0]);
        wr_data  = (wq.size() > 0) ? wq[0] : 8'h00;
        took     = wr_valid && wr_ready;
    end

    // scoreboard monitor
    logic [7:0] rdq[$];
    logic [AW-1:0] exp_addr = '0;
    int n_pulse = 0, n_mreq_fall = 0, n_done = 0;
    int wr_w = 0, rd_w = 0;
    logic p_mreq = 1'b1, p_wr = 1'b1, p_rd = 1'b1;
    logic [AW-1:0] p_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_wr_n && p_wr) begin
                n_pulse++;
                chk(mem_addr == p_addr, "R3 addr setup", mem_addr, p_addr);
                chk(mem_addr == exp_addr, "R5 addr step", mem_addr, exp_addr);
                exp_addr = exp_addr + 1'b1;
            end
            if (!mem_rd_n && p_rd) begin
                n_pulse++;
                chk(mem_addr == p_addr, "R4 addr setup", mem_addr, p_addr);
                chk(mem_addr == exp_addr, "R5 addr step", mem_addr, exp_addr);
                exp_addr = exp_addr + 1'b1;
            end
            if (!mem_wr_n) wr_w++;
            else if (!p_wr) begin
                chk(wr_w == WRW, "R3 wr width", wr_w, WRW);
                wr_w = 0;
            end
            if (!mem_rd_n) rd_w++;
            else if (!p_rd) begin
                chk(rd_w == RDW, "R4 rd width", rd_w, RDW);
                rd_w = 0;
            end
            if (!mem_mreq_n && p_mreq) n_mreq_fall++;
            if (done) begin
                n_done++;
                chk(mem_mreq_n && p_wr && p_rd, "R9 done with mreq high", mem_mreq_n, 1);
            end
            if (rd_valid) begin
                if (rdq.size() == 0) chk(1'b0, "R4 unexpected rd_valid", rd_data, 0);
                else begin
                    logic [7:0] e;
                    e = rdq.pop_front();
                    chk(rd_data == e, "R4 rd_data", rd_data, e);
                    chk(mem_rd_n, "R4 rd_valid as rd rises", mem_rd_n, 1);
                end
            end
        end
        p_mreq = mem_mreq_n; p_wr = mem_wr_n; p_rd = mem_rd_n; p_addr = mem_addr;
    end

    // driver
    task automatic run_cmd(input logic [AW-1:0] a, input int len, input bit w,
                           input bit f, input logic [7:0] fv,
                           input logic [7:0] data[$], input string req);
        int p0, m0, d0, waits;
        logic [AW-1:0] ai;
        p0 = n_pulse; m0 = n_mreq_fall; d0 = n_done;
        exp_addr = a;
        ai = a;
        for (int i = 0; i < len; i++) begin
            if (w) begin
                ref_mem[int'(ai)] = f ? fv : data[i];
                if (!f) wq.push_back(data[i]);
            end else begin
                rdq.push_back(ref_mem.exists(int'(ai)) ? ref_mem[int'(ai)] : 8'h00);
            end
            ai = ai + 1'b1;
        end
        @(negedge clk);
        cmd_addr = a; cmd_len = LW'(len); cmd_write = w; cmd_fill = f;
        cmd_fill_byte = fv; cmd_valid = 1'b1;
        forever begin
            if (cmd_ready) begin @(negedge clk); break; end
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        waits = 0;
        while (!done && waits < 500) begin @(negedge clk); waits++; end
        chk(done, {req, " done seen"}, done, 1);
        if (len == 0) chk(waits == 0, "R8 done next cycle", waits, 0);
        @(negedge clk);
        chk(n_pulse - p0 == len, {req, " strobe count"}, n_pulse - p0, len);
        chk(n_mreq_fall - m0 == (len > 0 ? 1 : 0), {req, " single mreq"},
            n_mreq_fall - m0, len > 0 ? 1 : 0);
        chk(n_done - d0 == 1, "R9 one done", n_done - d0, 1);
        ai = a;
        if (w)
            for (int i = 0; i < len; i++) begin
                logic [7:0] got;
                got = mem.exists(int'(ai)) ? mem[int'(ai)] : 8'hxx;
                chk(got === ref_mem[int'(ai)], {req, " mem contents"}, got, ref_mem[int'(ai)]);
                ai = ai + 1'b1;
            end
        chk(rdq.size() == 0, {req, " all reads returned"}, rdq.size(), 0);
    endtask

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] dq[$];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(mem_mreq_n && mem_rd_n && mem_wr_n, "R1 strobes high", {mem_mreq_n, mem_rd_n, mem_wr_n}, 7);
        chk(!mem_dout_oe && !rd_valid && !done, "R1 outputs idle", {mem_dout_oe, rd_valid, done}, 0);
        chk(!cmd_ready, "R1 no accept", cmd_ready, 0);
        // R2 released while not owned
        chk(!mem_ctl_oe, "R2 released", mem_ctl_oe, 0);
        bus_owned = 1'b1;
        @(negedge clk);
        chk(mem_ctl_oe && cmd_ready, "R2 owned", {mem_ctl_oe, cmd_ready}, 3);

        dq = '{8'hA5};
        run_cmd(19'h01234, 1, 1'b1, 1'b0, 8'h00, dq, "R3");
        dq = '{};
        run_cmd(19'h01234, 1, 1'b0, 1'b0, 8'h00, dq, "R4");

        dq = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
        run_cmd(19'h00010, 5, 1'b1, 1'b0, 8'h00, dq, "R5");
        stall_en = 1'b1;
        dq = '{8'h9A, 8'hBC, 8'hDE, 8'hF0, 8'h12};
        run_cmd(19'h00100, 5, 1'b1, 1'b0, 8'h00, dq, "R7");
        stall_en = 1'b0;
        dq = '{};
        run_cmd(19'h00010, 5, 1'b0, 1'b0, 8'h00, dq, "R5");
        run_cmd(19'h00100, 5, 1'b0, 1'b0, 8'h00, dq, "R7");

        // R6 fill: stream left holding a byte that must not be taken
        wq.push_back(8'hEE);
        run_cmd(19'h40200, 6, 1'b1, 1'b1, 8'h3C, dq, "R6");
        chk(wq.size() == 1, "R6 stream untouched", wq.size(), 1);
        wq.delete();
        @(negedge clk);
        run_cmd(19'h40200, 6, 1'b0, 1'b0, 8'h00, dq, "R6");

        run_cmd(19'h00500, 0, 1'b1, 1'b0, 8'h00, dq, "R8");

        dq = '{8'hC1, 8'hC2, 8'hC3};
        run_cmd(19'h7FFFE, 3, 1'b1, 1'b0, 8'h00, dq, "R10");
        dq = '{};
        run_cmd(19'h7FFFF, 2, 1'b0, 1'b0, 8'h00, dq, "R10");

        bus_owned = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!mem_ctl_oe && !cmd_ready, "R2 release", {mem_ctl_oe, cmd_ready}, 0);
        chk(mem_mreq_n && mem_rd_n && mem_wr_n, "R11 idle strobes", {mem_mreq_n, mem_rd_n, mem_wr_n}, 7);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule